// File: doc/BRIEF.md
# Nonvolatile Store Handshake Controller

This block sequences the backup of a battery-free nonvolatile SRAM. It watches two comparator flags: one says the main supply has dropped below its switch point, the other says the reservoir capacitor is too low to finish a backup. It also watches a shared, open-drain, active-low busy line that several memories may wire together. When the supply fails, or when any device on the shared line pulls it low, the controller coordinates a copy of the SRAM array into its nonvolatile cells. It does this through a start/done handshake with a separate store engine.

The controller drives the shared line only through a pull-low enable, and it reads the line back through a synchronizer. On a supply failure it pulls the line low for a fixed window. If the line has not actually gone low by the end of that window, because some stronger driver is holding it high, the controller gives up the attempt. A backup really runs only when the array has been written since the last store. In every other case the request finishes without the engine. After any request the memory stays locked until the shared line is seen high again.

Top module: `nv_store_ctrl`

## Requirements
- R1: After reset the controller is idle. `busy_drive_low` is 0 and `store_start` is 0. With `cap_low` low, `acc_enable` is 1.
- R2: `wr_ok` equals `wr_req` while `acc_enable` is 1 and is 0 otherwise. `acc_enable` is 1 only while idle with `cap_low` low.
- R3: When `supply_low` is high in idle, `busy_drive_low` rises on the next cycle and stays high for exactly `WINDOW_CYCLES` cycles. If the synchronized line is still high when the window ends, the drive drops, no store starts, and access stays blocked until `supply_low` falls.
- R4: If the synchronized line is low when the window ends and the array is dirty, `store_start` is high for exactly one cycle. `busy_drive_low` stays high from then until `store_done` is pulsed.
- R5: If the line is low when the window ends but the array is clean, no `store_start` occurs and the drive drops right after the window.
- R6: With `cap_low` low, a low on the synchronized shared line while idle counts as a store request. A dirty array starts a store with a `store_start` pulse and the line held low.
- R7: While `cap_low` is high, an external low on the shared line is ignored. The controller does not drive the line, does not pulse `store_start`, and keeps the array dirty.
- R8: After `store_done` ends a store, `busy_drive_low` falls on the next cycle. `acc_enable` stays 0 until the synchronized line is high again.
- R9: An accepted write marks the array dirty, and an accepted `store_done` clears it. A later request with no write in between runs no store.
- R10: A supply-low store attempt fires once per assertion of `supply_low`. Another attempt needs `supply_low` to go low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_low | input | 1 | Main supply below switch threshold |
| cap_low | input | 1 | Reservoir capacitor below threshold |
| busy_line | input | 1 | Raw level of the shared active-low busy line |
| busy_drive_low | output | 1 | Enable for the pull-down on the shared line |
| wr_req | input | 1 | SRAM write request |
| wr_ok | output | 1 | Write accepted this cycle |
| acc_enable | output | 1 | Chip access (read/write) permitted |
| store_start | output | 1 | One-cycle start pulse to the store engine |
| store_done | input | 1 | Store engine completion pulse |

## Verification
The bench builds the block with `WINDOW_CYCLES` set to 8 and `SYNC_STAGES` set to 2. The short window lets the bench count the exact length of the pull-down and of the abort path. It also leaves room for the two-flop read-back of the block's own pull to settle well before the window ends. With these values, supply-low attempts, external requests, ignored requests under a low capacitor, and the lock-out waiting on a line held low by another device can all be exercised many times within a short run.

// File: rtl/nv_store_pkg.sv
package nv_store_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WINDOW   = 3'd1,
      ST_STORING  = 3'd2,
      ST_RELEASE  = 3'd3,
      ST_ABORTED  = 3'd4
   } nv_state_e;
endpackage

// File: rtl/nv_line_sync.sv
// Multi-stage synchronizer for the shared busy line; resets to the idle (high) level.
module nv_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_raw,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nv_window_timer.sv
// Down-counter that measures the initial pull-down window.
module nv_window_timer #(
   parameter int WINDOW_CYCLES = 4000,
   localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= LOAD_VAL;
      else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nv_dirty_track.sv
// Remembers whether the array was written since the last completed store.
module nv_dirty_track (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_accept,
   input  logic store_ack,
   output logic dirty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dirty <= 1'b0;
      else if (store_ack)  dirty <= 1'b0;
      else if (wr_accept)  dirty <= 1'b1;
   end
endmodule

// File: rtl/nv_store_fsm.sv
// Store sequencing state machine.
module nv_store_fsm
   import nv_store_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      supply_low,
   input  logic      cap_low,
   input  logic      line_hi,
   input  logic      win_expired,
   input  logic      dirty,
   input  logic      store_done,
   output logic      win_load,
   output logic      win_run,
   output nv_state_e state_q,
   output logic      store_start,
   output logic      drive_low,
   output logic      access_ok,
   output logic      done_ack
);
   nv_state_e state_d;
   logic      armed_q;
   logic      armed_d;
   logic      go_store;

   // Common outcome once a store request is confirmed.
   assign go_store = dirty;

   always_comb begin
      state_d  = state_q;
      win_load = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (supply_low && armed_q) begin
               state_d  = ST_WINDOW;
               win_load = 1'b1;
            end else if (!line_hi && !cap_low) begin
               state_d = go_store ? ST_STORING : ST_RELEASE;
            end
         end
         ST_WINDOW: begin
            if (win_expired) begin
               if (line_hi) state_d = ST_ABORTED;
               else         state_d = go_store ? ST_STORING : ST_RELEASE;
            end
         end
         ST_STORING: begin
            if (store_done) state_d = ST_RELEASE;
         end
         ST_RELEASE: begin
            if (line_hi) state_d = ST_IDLE;
         end
         ST_ABORTED: begin
            if (!supply_low) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      armed_d = armed_q;
      if (win_load)         armed_d = 1'b0;
      else if (!supply_low) armed_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         armed_q     <= 1'b1;
         store_start <= 1'b0;
      end else begin
         state_q     <= state_d;
         armed_q     <= armed_d;
         store_start <= (state_d == ST_STORING) && (state_q != ST_STORING);
      end
   end

   assign win_run   = (state_q == ST_WINDOW);
   assign drive_low = (state_q == ST_WINDOW) || (state_q == ST_STORING);
   assign access_ok = (state_q == ST_IDLE) && !cap_low;
   assign done_ack  = (state_q == ST_STORING) && store_done;
endmodule

// File: rtl/nv_store_ctrl.sv
// Top level: nonvolatile store handshake controller.
module nv_store_ctrl
   import nv_store_pkg::*;
#(
   parameter int WINDOW_CYCLES = 4000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic cap_low,
   input  logic busy_line,
   output logic busy_drive_low,
   input  logic wr_req,
   output logic wr_ok,
   output logic acc_enable,
   output logic store_start,
   input  logic store_done
);
   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("nv_store_ctrl: SYNC_STAGES must be at least 2");
      end
      if (WINDOW_CYCLES <= SYNC_STAGES) begin : g_chk_window
         $error("nv_store_ctrl: WINDOW_CYCLES must exceed SYNC_STAGES");
      end
   endgenerate

   logic      line_hi;
   logic      win_load;
   logic      win_run;
   logic      win_expired;
   logic      dirty;
   logic      done_ack;
   nv_state_e state_q;

   nv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_raw  (busy_line),
      .q_sync (line_hi)
   );

   nv_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (win_load),
      .run     (win_run),
      .expired (win_expired)
   );

   nv_dirty_track u_dirty (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_accept (wr_ok),
      .store_ack (done_ack),
      .dirty     (dirty)
   );

   nv_store_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_low  (supply_low),
      .cap_low     (cap_low),
      .line_hi     (line_hi),
      .win_expired (win_expired),
      .dirty       (dirty),
      .store_done  (store_done),
      .win_load    (win_load),
      .win_run     (win_run),
      .state_q     (state_q),
      .store_start (store_start),
      .drive_low   (busy_drive_low),
      .access_ok   (acc_enable),
      .done_ack    (done_ack)
   );

   assign wr_ok = wr_req && acc_enable;
endmodule

// File: rtl/nv_store_chk.sv
// Property checker bound into the controller.
module nv_store_chk
   import nv_store_pkg::*;
#(
   parameter int WINDOW_CYCLES = 4000,
   localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
   input logic      clk,
   input logic      rst_n,
   input logic      cap_low,
   input logic      supply_low,
   input logic      busy_drive_low,
   input logic      wr_ok,
   input logic      acc_enable,
   input logic      store_start,
   input logic      store_done,
   input nv_state_e state_q
);
   logic [CNT_W-1:0] win_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    win_cyc <= '0;
      else if (state_q == ST_WINDOW) win_cyc <= win_cyc + 1'b1;
      else                           win_cyc <= '0;
   end

   p_write_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> (acc_enable && !cap_low));

   p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WINDOW) |-> (win_cyc < CNT_W'(WINDOW_CYCLES)));

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |=> !store_start);

   p_start_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> busy_drive_low);

   p_hold_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STORING && !store_done) |=> busy_drive_low);

   p_cap_ignores_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && cap_low && !supply_low) |=> !store_start);

   p_locked_while_driving_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_drive_low |-> !acc_enable);

   p_release_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STORING && store_done) |=> (!busy_drive_low && !acc_enable));
endmodule

bind nv_store_ctrl nv_store_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cap_low        (cap_low),
   .supply_low     (supply_low),
   .busy_drive_low (busy_drive_low),
   .wr_ok          (wr_ok),
   .acc_enable     (acc_enable),
   .store_start    (store_start),
   .store_done     (store_done),
   .state_q        (state_q)
);

// File: tb/nv_store_ctrl_test.sv
module nv_store_ctrl_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low = 1'b0;
   logic cap_low = 1'b0;
   logic ext_pull = 1'b0;
   logic ext_hold = 1'b0;
   logic wr_req = 1'b0;
   logic store_done = 1'b0;
   logic busy_line;
   logic busy_drive_low, wr_ok, acc_enable, store_start;

   int checks = 0;
   int fails = 0;
   int starts = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   // Wired-AND line model; ext_hold overpowers every pull-down.
   assign busy_line = ext_hold ? 1'b1 : !(busy_drive_low || ext_pull);

   nv_store_ctrl #(.WINDOW_CYCLES(W), .SYNC_STAGES(2)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .supply_low     (supply_low),
      .cap_low        (cap_low),
      .busy_line      (busy_line),
      .busy_drive_low (busy_drive_low),
      .wr_req         (wr_req),
      .wr_ok          (wr_ok),
      .acc_enable     (acc_enable),
      .store_start    (store_start),
      .store_done     (store_done)
   );

   always @(negedge clk) if (store_start) starts++;

   // bits: {cap_low, wr_req, expected acc_enable, expected wr_ok}
   localparam logic [3:0] VEC [4] = '{4'b0010, 4'b0111, 4'b1100, 4'b1000};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_window(output int n, output bit started);
      int guard = 0;
      n = 0;
      while (!busy_drive_low && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      while (busy_drive_low && !store_start && n < 100) begin
         n++;
         @(negedge clk);
      end
      started = store_start;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      bit st;
      int snap;

      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 drive", busy_drive_low, 0);
      chk("R1 start", store_start, 0);
      chk("R1 access", acc_enable, 1);

      // R2 vector table in idle
      for (int i = 0; i < 4; i++) begin
         cap_low = VEC[i][3];
         wr_req  = VEC[i][2];
         #1;
         chk("R2 acc_enable", acc_enable, VEC[i][1]);
         chk("R2 wr_ok", wr_ok, VEC[i][0]);
         @(negedge clk);
         wr_req = 1'b0;
      end
      cap_low = 1'b0;
      tick(1);

      // R3 abort: line held high by an external driver
      ext_hold = 1'b1;
      supply_low = 1'b1;
      snap = starts;
      run_window(n, st);
      chk("R3 window length", n, W);
      chk("R3 no start", st, 0);
      chk("R3 drive released", busy_drive_low, 0);
      tick(3);
      chk("R3 locked while aborted", acc_enable, 0);
      chk("R3 start count", starts, snap);
      supply_low = 1'b0;
      ext_hold = 1'b0;
      tick(2);
      chk("R3 back to idle", acc_enable, 1);

      // R4 dirty store on supply low
      supply_low = 1'b1;
      run_window(n, st);
      chk("R4 window before start", n, W);
      chk("R4 start seen", st, 1);
      tick(1);
      chk("R4 start one cycle", store_start, 0);
      tick(10);
      chk("R4 drive held", busy_drive_low, 1);
      wr_req = 1'b1;
      #1;
      chk("R2 write blocked during store", wr_ok, 0);
      wr_req = 1'b0;
      @(negedge clk);
      ext_pull = 1'b1;
      store_done = 1'b1;
      @(negedge clk);
      store_done = 1'b0;
      chk("R8 drive released after done", busy_drive_low, 0);
      chk("R8 locked after done", acc_enable, 0);
      tick(5);
      chk("R8 locked while line low", acc_enable, 0);
      ext_pull = 1'b0;
      tick(4);
      chk("R8 access after line high", acc_enable, 1);
      tick(10);
      chk("R10 no retrigger", busy_drive_low, 0);
      chk("R10 single start", starts, snap + 1);

      // R5 / R9: clean array after store
      supply_low = 1'b0;
      tick(2);
      snap = starts;
      supply_low = 1'b1;
      run_window(n, st);
      chk("R5 window length", n, W);
      chk("R9 no store when clean", st, 0);
      tick(4);
      chk("R5 access back", acc_enable, 1);
      chk("R5 start count", starts, snap);
      supply_low = 1'b0;
      tick(2);

      // R7: external request ignored while capacitor low
      wr_req = 1'b1;
      #1;
      chk("R2 write accepted", wr_ok, 1);
      @(negedge clk);
      wr_req = 1'b0;
      cap_low = 1'b1;
      ext_pull = 1'b1;
      snap = starts;
      tick(10);
      chk("R7 no drive", busy_drive_low, 0);
      chk("R7 no start", starts, snap);
      ext_pull = 1'b0;
      tick(4);
      cap_low = 1'b0;
      tick(1);
      chk("R7 access after", acc_enable, 1);

      // R6: external request starts a store; dirty kept through R7
      ext_pull = 1'b1;
      n = 0;
      while (!store_start && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk("R6 start on external", store_start, 1);
      chk("R6 drive during store", busy_drive_low, 1);
      store_done = 1'b1;
      ext_pull = 1'b0;
      @(negedge clk);
      store_done = 1'b0;
      tick(4);
      chk("R6 access after", acc_enable, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule